// File: doc/BRIEF.md
# Five-Stage Interlocked In-Order Pipeline

This block is an in-order instruction pipeline with five stages: fetch, primary decode, translate, execute and write-back. Each stage holds one instruction, so up to five are in flight. Instructions carry a two-bit opcode, a destination register, two source registers and a 16-bit immediate. They operate on a register file of eight 16-bit entries, and the datapath supports XOR, ADD, SUB and load-immediate.

There is no bypass network. When an instruction in primary decode reads a register that an instruction in translate or execute will write, the block holds decode and fetch, refuses new input and sends a bubble into translate. The held instruction proceeds once the producer has reached write-back. Write-back updates the register file early enough in its cycle that decode reads the new value in that same cycle. Completed instructions leave in program order on a retirement port, and a retirement counter follows them.

Top module: `interlock_pipe5`

## Requirements
- R1: After synchronous reset, every stage is empty (`stage_busy` = 0), `ret_valid` is 0, `ret_count` is 0 and `in_ready` is 1.
- R2: With no hazard, an instruction accepted at clock edge k moves one stage per edge and is shown on `ret_valid`/`ret_rd`/`ret_data` after edge k+4. `stage_busy` bit 0 is fetch, bit 1 decode, bit 2 translate, bit 3 execute and bit 4 write-back.
- R3: Without hazards the block accepts an instruction on every cycle. Five instructions accepted back to back fill all five stages (`stage_busy` = 5'b11111) with no cycle of `in_ready` low.
- R4: A decode instruction whose rs1 or rs2 matches the destination of a valid instruction in translate or execute holds decode and fetch, drives `in_ready` low and inserts a bubble into translate. A producer directly ahead costs two stall cycles, and a producer with one instruction between costs one.
- R5: A producer that is already in write-back causes no stall. The dependent instruction receives the value being written in that same cycle.
- R6: Opcode encoding: 2'b00 gives rd = rs1 XOR rs2; 2'b01 gives rd = rs1 + rs2 modulo 2^16; 2'b10 gives rd = `in_imm`; 2'b11 gives rd = rs1 - rs2 modulo 2^16.
- R7: The source fields of a load-immediate (opcode 2'b10) are ignored by hazard detection, so it never stalls.
- R8: Instructions retire in program order with their destination and result. `ret_count` rises by one for each retirement, visible one cycle after the retirement is shown.
- R9: The three-instruction XOR swap r1^=r2, r2^=r1, r1^=r2 leaves the two registers exchanged. Its two dependent instructions stall twice, for four stall cycles in total.
- R10: Register 0 is an ordinary register that can be written and read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Fetch can accept (low while decode is held) |
| in_op | input | 2 | Opcode (see R6) |
| in_rd | input | 3 | Destination register |
| in_rs1 | input | 3 | First source register |
| in_rs2 | input | 3 | Second source register |
| in_imm | input | 16 | Immediate for load-immediate |
| stage_busy | output | 5 | Per-stage occupancy, bit 0 fetch to bit 4 write-back |
| ret_valid | output | 1 | An instruction retires this cycle |
| ret_rd | output | 3 | Destination of the retiring instruction |
| ret_data | output | 16 | Result written by the retiring instruction |
| ret_count | output | 16 | Number of retired instructions |

## Verification
The pipeline is exercised with several stream shapes:
- Independent back-to-back loads show full throughput and a full pipe.
- A lone instruction pins the four-edge latency.
- Dependences at distances one, two and three tell the two-cycle, one-cycle and zero-cycle stall cases apart, and the distance-three case also proves the same-cycle write-through value.
- The XOR swap and a dependence through rs2 only confirm correct results and stall counts.
- A load-immediate whose unused source fields name an in-flight destination shows that those fields are ignored.
- Every retirement is compared against a sequential architectural model.

// File: rtl/ipipe_pkg.sv
package ipipe_pkg;
  typedef enum logic [1:0] {
    OP_XOR = 2'b00,
    OP_ADD = 2'b01,
    OP_LDI = 2'b10,
    OP_SUB = 2'b11
  } op_e;

  localparam int NSTAGE = 5;
  localparam int OLDER  = 2;  // stages checked for hazards: translate, execute
endpackage

// File: rtl/ipipe_alu.sv
module ipipe_alu
  import ipipe_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  op_e               op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] y
);
  always_comb begin
    case (op)
      OP_XOR:  y = a ^ b;
      OP_ADD:  y = a + b;
      OP_SUB:  y = a - b;
      default: y = b;  // load-immediate: operand b carries the immediate
    endcase
  end
endmodule

// File: rtl/ipipe_regfile.sv
module ipipe_regfile #(
  parameter int DATA_W = 16,
  parameter int NREG   = 8,
  parameter int NRD    = 2,
  localparam int RA_W  = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [RA_W-1:0]   waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [RA_W-1:0]   raddr [NRD],
  output logic [DATA_W-1:0] rdata [NRD]
);
  logic [DATA_W-1:0] mem [NREG];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // The write lands early in the cycle: a reader in the same cycle sees it.
  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rdata[p] = (we && waddr == raddr[p]) ? wdata : mem[raddr[p]];
  end
endmodule

// File: rtl/ipipe_hazard.sv
module ipipe_hazard
  import ipipe_pkg::*;
#(
  parameter int RA_W = 3
) (
  input  logic            dec_valid,
  input  logic            dec_reads,
  input  logic [RA_W-1:0] dec_rs1,
  input  logic [RA_W-1:0] dec_rs2,
  input  logic            old_valid [OLDER],
  input  logic [RA_W-1:0] old_rd    [OLDER],
  output logic            stall
);
  always_comb begin
    stall = 1'b0;
    for (int s = 0; s < OLDER; s++) begin
      if (dec_valid && dec_reads && old_valid[s] &&
          (old_rd[s] == dec_rs1 || old_rd[s] == dec_rs2))
        stall = 1'b1;
    end
  end
endmodule

// File: rtl/interlock_pipe5.sv
module interlock_pipe5
  import ipipe_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int NREG   = 8,
  parameter int CNT_W  = 16,
  localparam int RA_W  = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        in_op,
  input  logic [RA_W-1:0]   in_rd,
  input  logic [RA_W-1:0]   in_rs1,
  input  logic [RA_W-1:0]   in_rs2,
  input  logic [DATA_W-1:0] in_imm,
  output logic [NSTAGE-1:0] stage_busy,
  output logic              ret_valid,
  output logic [RA_W-1:0]   ret_rd,
  output logic [DATA_W-1:0] ret_data,
  output logic [CNT_W-1:0]  ret_count
);
  typedef struct packed {
    op_e               op;
    logic [RA_W-1:0]   rd;
    logic [RA_W-1:0]   rs1;
    logic [RA_W-1:0]   rs2;
    logic [DATA_W-1:0] imm;
  } instr_t;

  logic              f_v, d_v, t_v, x_v, w_v;
  instr_t            f_q, d_q;
  op_e               t_op;
  logic [RA_W-1:0]   t_rd, x_rd, w_rd;
  logic [DATA_W-1:0] t_a, t_b, x_res, w_res, alu_y;
  logic              stall, adv;
  logic [RA_W-1:0]   rf_ra [2];
  logic [DATA_W-1:0] rf_rd [2];
  logic              old_v [OLDER];
  logic [RA_W-1:0]   old_rd [OLDER];

  assign adv      = !stall;
  assign in_ready = adv;

  // fetch
  always_ff @(posedge clk) begin
    if (rst) f_v <= 1'b0;
    else if (adv) begin
      f_v <= in_valid;
      f_q <= '{op: op_e'(in_op), rd: in_rd, rs1: in_rs1, rs2: in_rs2, imm: in_imm};
    end
  end

  // primary decode
  always_ff @(posedge clk) begin
    if (rst) d_v <= 1'b0;
    else if (adv) begin
      d_v <= f_v;
      d_q <= f_q;
    end
  end

  assign old_v[0]  = t_v;
  assign old_rd[0] = t_rd;
  assign old_v[1]  = x_v;
  assign old_rd[1] = x_rd;

  ipipe_hazard #(.RA_W(RA_W)) u_haz (
    .dec_valid (d_v),
    .dec_reads (d_q.op != OP_LDI),
    .dec_rs1   (d_q.rs1),
    .dec_rs2   (d_q.rs2),
    .old_valid (old_v),
    .old_rd    (old_rd),
    .stall     (stall)
  );

  assign rf_ra[0] = d_q.rs1;
  assign rf_ra[1] = d_q.rs2;

  ipipe_regfile #(.DATA_W(DATA_W), .NREG(NREG), .NRD(2)) u_rf (
    .clk   (clk),
    .we    (w_v),
    .waddr (w_rd),
    .wdata (w_res),
    .raddr (rf_ra),
    .rdata (rf_rd)
  );

  // translate: operands latched, bubble while decode is held
  always_ff @(posedge clk) begin
    if (rst) t_v <= 1'b0;
    else     t_v <= d_v && adv;
    t_op <= d_q.op;
    t_rd <= d_q.rd;
    t_a  <= rf_rd[0];
    t_b  <= (d_q.op == OP_LDI) ? d_q.imm : rf_rd[1];
  end

  ipipe_alu #(.DATA_W(DATA_W)) u_alu (.op(t_op), .a(t_a), .b(t_b), .y(alu_y));

  // execute and write-back
  always_ff @(posedge clk) begin
    if (rst) begin
      x_v <= 1'b0;
      w_v <= 1'b0;
    end else begin
      x_v <= t_v;
      w_v <= x_v;
    end
    x_rd  <= t_rd;
    x_res <= alu_y;
    w_rd  <= x_rd;
    w_res <= x_res;
  end

  always_ff @(posedge clk) begin
    if (rst)      ret_count <= '0;
    else if (w_v) ret_count <= ret_count + CNT_W'(1);
  end

  assign stage_busy = {w_v, x_v, t_v, d_v, f_v};
  assign ret_valid  = w_v;
  assign ret_rd     = w_rd;
  assign ret_data   = w_res;

  p_bubble_r4: assert property (@(posedge clk) disable iff (rst)
    stall |=> !t_v);
  p_hold_dec_r4: assert property (@(posedge clk) disable iff (rst)
    stall |=> (d_v && $stable(d_q)));
  p_accept_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> f_v);
  p_count_step_r8: assert property (@(posedge clk) disable iff (rst)
    ret_valid |=> ret_count == $past(ret_count) + CNT_W'(1));
  p_count_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !ret_valid |=> $stable(ret_count));
endmodule

// File: tb/interlock_pipe5_test.sv
module interlock_pipe5_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  in_op = 2'b00;
  logic [2:0]  in_rd = '0, in_rs1 = '0, in_rs2 = '0;
  logic [15:0] in_imm = '0;
  logic [4:0]  stage_busy;
  logic        ret_valid;
  logic [2:0]  ret_rd;
  logic [15:0] ret_data;
  logic [15:0] ret_count;

  always #10 clk = ~clk;  // 50 MHz

  interlock_pipe5 uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_rd(in_rd), .in_rs1(in_rs1), .in_rs2(in_rs2),
    .in_imm(in_imm), .stage_busy(stage_busy), .ret_valid(ret_valid),
    .ret_rd(ret_rd), .ret_data(ret_data), .ret_count(ret_count)
  );

  int nchk = 0, nerr = 0, nready_lo = 0, seen = 0, sent = 0;
  bit done = 1'b0;
  logic [15:0] model_rf [8];
  logic [18:0] expq [$];  // {rd, data}
  logic [15:0] last_data;

  task automatic check(string req, string what, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Reference model compared on every clock (sampled at the falling edge).
  always @(negedge clk) begin
    if (!rst) begin
      if (!in_ready) nready_lo++;
      check("R8", "ret_count", int'(ret_count), seen);
      if (ret_valid) begin
        if (expq.size() == 0) check("R8", "unexpected retire", 1, 0);
        else begin
          logic [18:0] e;
          e = expq.pop_front();
          check("R8", "retire rd", int'(ret_rd), int'(e[18:16]));
          check("R6", "retire data", int'(ret_data), int'(e[15:0]));
        end
        last_data = ret_data;
        seen++;
      end
    end
  end

  task automatic send(logic [1:0] op, logic [2:0] rd, logic [2:0] rs1,
                      logic [2:0] rs2, logic [15:0] imm);
    logic [15:0] r;
    bit rdy;
    case (op)
      2'b00:   r = model_rf[rs1] ^ model_rf[rs2];
      2'b01:   r = model_rf[rs1] + model_rf[rs2];
      2'b10:   r = imm;
      default: r = model_rf[rs1] - model_rf[rs2];
    endcase
    model_rf[rd] = r;
    expq.push_back({rd, r});
    sent++;
    in_valid = 1'b1; in_op = op; in_rd = rd; in_rs1 = rs1; in_rs2 = rs2; in_imm = imm;
    forever begin
      rdy = in_ready;
      @(negedge clk);
      if (rdy) break;
    end
    in_valid = 1'b0;
  endtask

  task automatic drain();
    while (stage_busy != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) model_rf[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1", "stage_busy", int'(stage_busy), 0);
    check("R1", "ret_valid", int'(ret_valid), 0);
    check("R1", "ret_count", int'(ret_count), 0);
    check("R1", "in_ready", int'(in_ready), 1);

    // R2 latency of a lone instruction
    send(2'b10, 3'd1, 3'd0, 3'd0, 16'h1234);
    begin
      int n = 0;
      while (!ret_valid && n < 20) begin @(negedge clk); n++; end
      check("R2", "accept-to-retire edges", n, 4);
    end
    drain();

    // R3 back-to-back independent loads fill the pipe; R10 writes r0
    nready_lo = 0;
    send(2'b10, 3'd2, 3'd0, 3'd0, 16'hABCD);
    send(2'b10, 3'd3, 3'd0, 3'd0, 16'h0003);
    send(2'b10, 3'd4, 3'd0, 3'd0, 16'h0005);
    send(2'b10, 3'd0, 3'd0, 3'd0, 16'hFFFF);
    send(2'b10, 3'd5, 3'd0, 3'd0, 16'h0002);
    check("R3", "stage_busy full", int'(stage_busy), 5'h1F);
    drain();
    check("R3", "stall cycles in burst", nready_lo, 0);

    // R9 XOR swap
    nready_lo = 0;
    send(2'b00, 3'd1, 3'd1, 3'd2, 16'h0);
    send(2'b00, 3'd2, 3'd2, 3'd1, 16'h0);
    send(2'b00, 3'd1, 3'd1, 3'd2, 16'h0);
    drain();
    check("R9", "swap stall cycles", nready_lo, 4);
    check("R9", "r1 after swap", int'(last_data), 16'hABCD);
    send(2'b00, 3'd7, 3'd2, 3'd0, 16'h0);  // r2 ^ r0
    drain();
    check("R9", "r2 after swap", int'(last_data), 16'h1234 ^ 16'hFFFF);

    // R6 / R10 arithmetic wrap, r0 as an ordinary source
    send(2'b01, 3'd6, 3'd0, 3'd5, 16'h0);
    drain();
    check("R10", "r0 + r5 wraps", int'(last_data), 16'h0001);
    send(2'b11, 3'd7, 3'd3, 3'd4, 16'h0);
    drain();
    check("R6", "3 - 5 wraps", int'(last_data), 16'hFFFE);

    // R4 dependence through rs2 at distance one
    nready_lo = 0;
    send(2'b01, 3'd3, 3'd3, 3'd4, 16'h0);
    send(2'b00, 3'd5, 3'd0, 3'd3, 16'h0);
    drain();
    check("R4", "distance-1 stall cycles", nready_lo, 2);
    check("R4", "distance-1 result", int'(last_data), 16'hFFF7);

    // R4 dependence at distance two
    nready_lo = 0;
    send(2'b10, 3'd1, 3'd0, 3'd0, 16'h0F0F);
    send(2'b10, 3'd2, 3'd0, 3'd0, 16'h0007);
    send(2'b01, 3'd6, 3'd1, 3'd7, 16'h0);
    drain();
    check("R4", "distance-2 stall cycles", nready_lo, 1);

    // R5 producer in write-back: no stall, same-cycle value
    nready_lo = 0;
    send(2'b10, 3'd4, 3'd0, 3'd0, 16'h1111);
    send(2'b10, 3'd2, 3'd0, 3'd0, 16'h0001);
    send(2'b10, 3'd3, 3'd0, 3'd0, 16'h0002);
    send(2'b00, 3'd5, 3'd4, 3'd0, 16'h0);
    drain();
    check("R5", "distance-3 stall cycles", nready_lo, 0);
    check("R5", "write-through value", int'(last_data), 16'hEEEE);

    // R7 load-immediate source fields ignored
    nready_lo = 0;
    send(2'b01, 3'd1, 3'd2, 3'd3, 16'h0);
    send(2'b10, 3'd6, 3'd1, 3'd1, 16'h5A5A);
    drain();
    check("R7", "ldi stall cycles", nready_lo, 0);
    check("R7", "ldi result", int'(last_data), 16'h5A5A);

    // R8 totals
    check("R8", "final ret_count", int'(ret_count), sent);
    check("R8", "queue empty", expq.size(), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule